// File: doc/BRIEF.md
# Debug-to-SPR Register Access Bridge

This block sits between a debug interconnect and a processor's special-purpose-register (SPR) bus. It turns a debug register read or write into one SPR bus access. The upper half of the debug register address space acts as a window onto SPR space. Any debug address with its top bit set is forwarded, and its lower 15 bits become the low SPR address bits. A small local register, the page register, supplies the SPR address bits above that window. It keeps its value between accesses, so a run of SPR accesses that stay on one page costs exactly one debug transaction each.

The SPR address is built as `(page << 15) | (debug_addr - 0x8000)`. No group or address is filtered. The page register's width is a parameter, so a core with a wider SPR address needs only a parameter change. The page register lives at a fixed debug address below the window. Any other address below the window is answered at once with zero data and a one-cycle error flag. While an SPR access waits for its acknowledge, the debug side is held off by dropping ready.

Top module: `dbg_spr_bridge`

## Requirements
- R1: After a synchronous reset, dbg_req_ready is 1, spr_req is 0, dbg_rsp_valid is 0 and the page register reads as 0.
- R2: A request accepted (valid and ready high at a rising edge) with dbg_req_addr[15]=1 raises spr_req in the following cycle. In that cycle spr_addr = {page, dbg_req_addr[14:0]}, spr_we equals the write flag and spr_wdata equals dbg_req_wdata.
- R3: The page register answers at debug address 0x0100. A write stores dbg_req_wdata[0] (the low UPPER_W bits). A read returns the page value zero-extended to 32 bits. Either access gives dbg_rsp_valid=1 with dbg_rsp_err=0 one cycle after acceptance.
- R4: The page register keeps its value across any number of window accesses and unmapped accesses, so later window accesses use it without a rewrite.
- R5: From the cycle after a window request is accepted until spr_ack is sampled high, dbg_req_ready is 0. During that time spr_req, spr_addr, spr_we and spr_wdata hold steady.
- R6: One cycle after the edge at which spr_ack is seen with spr_req high, spr_req is 0, dbg_req_ready is 1, and dbg_rsp_valid pulses for exactly one cycle with dbg_rsp_err=0. dbg_rsp_rdata carries spr_rdata for a read and 0 for a write.
- R7: An accepted request below 0x8000 at any address other than 0x0100 gives dbg_rsp_valid=1, dbg_rsp_err=1 and dbg_rsp_rdata=0 one cycle later, for one cycle. It raises no spr_req, and a write to it leaves the page register unchanged.
- R8: Every address in the window is forwarded, including the bounds 0x8000 and 0xFFFF.
- R9: spr_ack arriving while no SPR request is pending produces no response.
- R10: SPR data passes at its full 32-bit width in both directions, with no splitting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_req_valid | input | 1 | Debug request present |
| dbg_req_ready | output | 1 | Bridge can take a request |
| dbg_req_write | input | 1 | 1 = write, 0 = read |
| dbg_req_addr | input | 16 | Debug register address |
| dbg_req_wdata | input | 32 | Debug write data |
| dbg_rsp_valid | output | 1 | One-cycle completion pulse |
| dbg_rsp_rdata | output | 32 | Read data for the completed access |
| dbg_rsp_err | output | 1 | Completed access hit an unmapped address |
| spr_req | output | 1 | SPR access request |
| spr_we | output | 1 | SPR write enable |
| spr_addr | output | 16 | SPR address |
| spr_wdata | output | 32 | SPR write data |
| spr_ack | input | 1 | SPR access acknowledge |
| spr_rdata | input | 32 | SPR read data |

## Verification
Each result has a fixed due cycle. A window request shows spr_req and its fields one edge after acceptance. A local or unmapped access completes one edge after acceptance. An SPR completion responds one edge after the acknowledge is sampled. The bench drives at falling edges and samples at the falling edge that follows the edge where the result is due. It varies the acknowledge delay per vector, checks that the request fields hold and ready stays low at every falling edge in between, and checks one cycle later that each response has fallen back.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  typedef enum logic [1:0] {
    ACC_SPR  = 2'd0,
    ACC_PAGE = 2'd1,
    ACC_NONE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/dsb_decode.sv
module dsb_decode
  import dsb_pkg::*;
#(
  parameter int DADDR_W = 16,
  parameter logic [DADDR_W-1:0] PAGE_ADDR = 16'h0100,
  localparam int WIN_W = DADDR_W - 1
) (
  input  logic [DADDR_W-1:0] addr,
  output acc_kind_e          kind,
  output logic [WIN_W-1:0]   offset
);
  // With the top bit set, dropping it equals subtracting the window base.
  assign offset = addr[WIN_W-1:0];

  always_comb begin
    if (addr[DADDR_W-1])
      kind = ACC_SPR;
    else if (addr == PAGE_ADDR)
      kind = ACC_PAGE;
    else
      kind = ACC_NONE;
  end
endmodule

// File: rtl/dsb_page_reg.sv
module dsb_page_reg #(
  parameter int UPPER_W = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [UPPER_W-1:0] wval,
  output logic [UPPER_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (we)
      q <= wval;
  end

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q)); // R4
endmodule

// File: rtl/dsb_spr_port.sv
module dsb_spr_port #(
  parameter int SPR_AW = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_we,
  input  logic [SPR_AW-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  output logic              busy,
  output logic              spr_req,
  output logic              spr_we,
  output logic [SPR_AW-1:0] spr_addr,
  output logic [DATA_W-1:0] spr_wdata,
  input  logic              spr_ack,
  input  logic [DATA_W-1:0] spr_rdata,
  output logic              finish,
  output logic [DATA_W-1:0] finish_rdata
);
  assign busy         = spr_req;
  assign finish       = spr_req & spr_ack;
  assign finish_rdata = spr_we ? '0 : spr_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      spr_req   <= 1'b0;
      spr_we    <= 1'b0;
      spr_addr  <= '0;
      spr_wdata <= '0;
    end else if (!spr_req) begin
      if (start) begin
        spr_req   <= 1'b1;
        spr_we    <= start_we;
        spr_addr  <= start_addr;
        spr_wdata <= start_wdata;
      end
    end else if (spr_ack) begin
      spr_req <= 1'b0;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    spr_req && !spr_ack |=> spr_req && $stable(spr_addr)
                            && $stable(spr_we) && $stable(spr_wdata)); // R5
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    spr_req && spr_ack |=> !spr_req); // R6
endmodule

// File: rtl/dbg_spr_bridge.sv
module dbg_spr_bridge
  import dsb_pkg::*;
#(
  parameter int DADDR_W = 16,
  parameter int DATA_W  = 32,
  parameter int UPPER_W = 1,
  parameter logic [DADDR_W-1:0] PAGE_ADDR = 16'h0100,
  localparam int WIN_W  = DADDR_W - 1,
  localparam int SPR_AW = WIN_W + UPPER_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_req_valid,
  output logic              dbg_req_ready,
  input  logic              dbg_req_write,
  input  logic [DADDR_W-1:0] dbg_req_addr,
  input  logic [DATA_W-1:0] dbg_req_wdata,
  output logic              dbg_rsp_valid,
  output logic [DATA_W-1:0] dbg_rsp_rdata,
  output logic              dbg_rsp_err,
  output logic              spr_req,
  output logic              spr_we,
  output logic [SPR_AW-1:0] spr_addr,
  output logic [DATA_W-1:0] spr_wdata,
  input  logic              spr_ack,
  input  logic [DATA_W-1:0] spr_rdata
);
  acc_kind_e          kind;
  logic [WIN_W-1:0]   offset;
  logic [UPPER_W-1:0] page_q;
  logic               busy;
  logic               accept;
  logic               finish;
  logic [DATA_W-1:0]  finish_rdata;

  dsb_decode #(.DADDR_W(DADDR_W), .PAGE_ADDR(PAGE_ADDR)) u_dec (
    .addr   (dbg_req_addr),
    .kind   (kind),
    .offset (offset)
  );

  assign dbg_req_ready = ~busy;
  assign accept        = dbg_req_valid & dbg_req_ready;

  dsb_page_reg #(.UPPER_W(UPPER_W)) u_page (
    .clk  (clk),
    .rst  (rst),
    .we   (accept && kind == ACC_PAGE && dbg_req_write),
    .wval (dbg_req_wdata[UPPER_W-1:0]),
    .q    (page_q)
  );

  dsb_spr_port #(.SPR_AW(SPR_AW), .DATA_W(DATA_W)) u_port (
    .clk          (clk),
    .rst          (rst),
    .start        (accept && kind == ACC_SPR),
    .start_we     (dbg_req_write),
    .start_addr   ({page_q, offset}),
    .start_wdata  (dbg_req_wdata),
    .busy         (busy),
    .spr_req      (spr_req),
    .spr_we       (spr_we),
    .spr_addr     (spr_addr),
    .spr_wdata    (spr_wdata),
    .spr_ack      (spr_ack),
    .spr_rdata    (spr_rdata),
    .finish       (finish),
    .finish_rdata (finish_rdata)
  );

  // Completions from the SPR port and local accepts never coincide:
  // an accept needs ready, which is low for as long as the port is busy.
  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_rsp_valid <= 1'b0;
      dbg_rsp_err   <= 1'b0;
      dbg_rsp_rdata <= '0;
    end else begin
      dbg_rsp_valid <= finish | (accept && kind != ACC_SPR);
      dbg_rsp_err   <= accept && kind == ACC_NONE;
      if (finish)
        dbg_rsp_rdata <= finish_rdata;
      else if (accept && kind == ACC_PAGE && !dbg_req_write)
        dbg_rsp_rdata <= DATA_W'(page_q);
      else
        dbg_rsp_rdata <= '0;
    end
  end

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    spr_req |-> !dbg_req_ready); // R5
  AST_ACK_GIVES_RSP: assert property (@(posedge clk) disable iff (rst)
    spr_req && spr_ack |=> dbg_rsp_valid && !dbg_rsp_err); // R6
  AST_ERR_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
    dbg_rsp_err |-> dbg_rsp_valid); // R7
  AST_STRAY_ACK: assert property (@(posedge clk) disable iff (rst)
    !spr_req && !(dbg_req_valid && dbg_req_ready) |=> !dbg_rsp_valid); // R9
  AST_PAGE_BITS: assert property (@(posedge clk) disable iff (rst)
    spr_req |-> spr_addr[SPR_AW-1 -: UPPER_W] == page_q); // R2
endmodule

// File: tb/sim_dbg_spr_bridge.sv
module sim_dbg_spr_bridge;
  logic        clk = 1'b0;
  logic        rst;
  logic        dbg_req_valid, dbg_req_write;
  logic        dbg_req_ready;
  logic [15:0] dbg_req_addr;
  logic [31:0] dbg_req_wdata;
  logic        dbg_rsp_valid, dbg_rsp_err;
  logic [31:0] dbg_rsp_rdata;
  logic        spr_req, spr_we, spr_ack;
  logic [15:0] spr_addr;
  logic [31:0] spr_wdata, spr_rdata;

  int total = 0;
  int bad   = 0;
  logic page_m = 1'b0;

  always #5 clk = ~clk;

  dbg_spr_bridge u0 (
    .clk(clk), .rst(rst),
    .dbg_req_valid(dbg_req_valid), .dbg_req_ready(dbg_req_ready),
    .dbg_req_write(dbg_req_write), .dbg_req_addr(dbg_req_addr),
    .dbg_req_wdata(dbg_req_wdata), .dbg_rsp_valid(dbg_rsp_valid),
    .dbg_rsp_rdata(dbg_rsp_rdata), .dbg_rsp_err(dbg_rsp_err),
    .spr_req(spr_req), .spr_we(spr_we), .spr_addr(spr_addr),
    .spr_wdata(spr_wdata), .spr_ack(spr_ack), .spr_rdata(spr_rdata)
  );

  localparam int NV = 10;
  localparam logic        T_WR   [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0,
                                          1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic [15:0] T_ADDR [NV] = '{16'h0100, 16'h0100, 16'h8000, 16'hFFFF, 16'h1234,
                                          16'h0100, 16'h8011, 16'hC000, 16'h7FFF, 16'h0100};
  localparam logic [31:0] T_WD   [NV] = '{32'h1, 32'h0, 32'h0, 32'hA5A5_0F0F, 32'h0,
                                          32'hFFFF_FFFE, 32'h0, 32'h0, 32'h1, 32'h0};
  localparam logic [31:0] T_SRD  [NV] = '{32'h0, 32'h0, 32'hDEAD_BEEF, 32'h1357_9BDF, 32'h0,
                                          32'h0, 32'h0000_0001, 32'h8000_0001, 32'h0, 32'h0};
  localparam int          T_DLY  [NV] = '{0, 0, 0, 3, 0, 0, 1, 5, 0, 0};

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [15:0] addr,
                        input logic [31:0] wd, input logic [31:0] srd,
                        input int dly);
    logic [15:0] exp_a;
    logic [31:0] exp_rd;
    @(negedge clk);
    chk(dbg_req_ready == 1'b1, "R6 ready before request", 32'(dbg_req_ready), 32'h1);
    dbg_req_valid = 1'b1; dbg_req_write = wr; dbg_req_addr = addr; dbg_req_wdata = wd;
    @(negedge clk);
    dbg_req_valid = 1'b0;
    if (addr[15]) begin
      exp_a = {page_m, addr[14:0]};
      chk(spr_req == 1'b1, "R2 spr_req", 32'(spr_req), 32'h1);
      chk(spr_addr == exp_a, "R2 R8 spr_addr", 32'(spr_addr), 32'(exp_a));
      chk(spr_we == wr, "R2 spr_we", 32'(spr_we), 32'(wr));
      if (wr) chk(spr_wdata == wd, "R10 spr_wdata", spr_wdata, wd);
      for (int i = 0; i < dly; i++) begin
        chk(dbg_req_ready == 1'b0, "R5 ready low while waiting", 32'(dbg_req_ready), 32'h0);
        chk(spr_req == 1'b1 && spr_addr == exp_a, "R5 request held",
            32'(spr_addr), 32'(exp_a));
        @(negedge clk);
      end
      spr_ack = 1'b1; spr_rdata = srd;
      @(negedge clk);
      spr_ack = 1'b0; spr_rdata = 32'hFFFF_FFFF;
      exp_rd = wr ? 32'h0 : srd;
      chk(dbg_rsp_valid == 1'b1, "R6 rsp_valid", 32'(dbg_rsp_valid), 32'h1);
      chk(dbg_rsp_err == 1'b0, "R6 rsp_err", 32'(dbg_rsp_err), 32'h0);
      chk(dbg_rsp_rdata == exp_rd, "R6 R10 rsp_rdata", dbg_rsp_rdata, exp_rd);
      chk(spr_req == 1'b0 && dbg_req_ready == 1'b1, "R6 request released",
          32'(spr_req), 32'h0);
    end else begin
      if (addr == 16'h0100) begin
        exp_rd = wr ? 32'h0 : 32'(page_m);
        if (wr) page_m = wd[0];
        chk(dbg_rsp_err == 1'b0, "R3 page no error", 32'(dbg_rsp_err), 32'h0);
        chk(dbg_rsp_rdata == exp_rd, "R3 R4 page read", dbg_rsp_rdata, exp_rd);
      end else begin
        chk(dbg_rsp_err == 1'b1, "R7 error flag", 32'(dbg_rsp_err), 32'h1);
        chk(dbg_rsp_rdata == 32'h0, "R7 zero data", dbg_rsp_rdata, 32'h0);
      end
      chk(dbg_rsp_valid == 1'b1, "R3 R7 rsp_valid", 32'(dbg_rsp_valid), 32'h1);
      chk(spr_req == 1'b0, "R7 no spr_req", 32'(spr_req), 32'h0);
    end
    @(negedge clk);
    chk(dbg_rsp_valid == 1'b0 && dbg_rsp_err == 1'b0, "R6 R7 single-cycle pulse",
        32'({dbg_rsp_valid, dbg_rsp_err}), 32'h0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; dbg_req_valid = 1'b0; dbg_req_write = 1'b0;
    dbg_req_addr = '0; dbg_req_wdata = '0; spr_ack = 1'b0; spr_rdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dbg_req_ready == 1'b1, "R1 ready after reset", 32'(dbg_req_ready), 32'h1);
    chk(spr_req == 1'b0, "R1 spr_req after reset", 32'(spr_req), 32'h0);
    chk(dbg_rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(dbg_rsp_valid), 32'h0);
    access(1'b0, 16'h0100, 32'h0, 32'h0, 0); // R1: page reads 0

    for (int v = 0; v < NV; v++)
      access(T_WR[v], T_ADDR[v], T_WD[v], T_SRD[v], T_DLY[v]);

    // R9: acknowledge with nothing pending
    @(negedge clk);
    spr_ack = 1'b1; spr_rdata = 32'h1111_2222;
    @(negedge clk);
    spr_ack = 1'b0;
    chk(dbg_rsp_valid == 1'b0, "R9 stray ack ignored", 32'(dbg_rsp_valid), 32'h0);
    @(negedge clk);
    chk(dbg_rsp_valid == 1'b0, "R9 stray ack still ignored", 32'(dbg_rsp_valid), 32'h0);

    // R4: page set to 1, then unmapped write and two window accesses reuse it
    access(1'b1, 16'h0100, 32'h1, 32'h0, 0);
    access(1'b1, 16'h0002, 32'h0, 32'h0, 0);
    access(1'b0, 16'h8005, 32'h0, 32'h0BAD_CAFE, 2);
    access(1'b1, 16'hFFFE, 32'h0F0F_F0F0, 32'h0, 0);
    access(1'b0, 16'h0100, 32'h0, 32'h0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule